// File: doc/BRIEF.md
# Booth Radix-4 Multiply-Accumulate Unit

This block multiplies two signed 16-bit operands and adds the product into a 32-bit accumulator register, finishing one multiply-accumulate on every enabled clock edge. Nothing is pipelined. The only storage element is the accumulator, so a new pair of operands can be presented on every cycle.

The multiplier operand is recoded into eight radix-4 signed digits. Each digit selects zero, once or twice the multiplicand, optionally negated, and this gives one partial product. A partial product that is negated is built by inverting the bits and adding a +1 correction bit at the digit's own weight. The partial products pass through a linear chain of carry-save rows. The first row takes the previous accumulator value together with the correction bits, so the feedback path is folded into the array and no separate adder follows the product. One carry-propagate adder at the bottom of the chain resolves the redundant sum.

A synchronous clear and an accumulate enable together select what the register loads on the next edge. When both are asserted, the accumulator is seeded with the new product.

Top module: `booth_mac`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, `accOut` becomes 0 after that edge.
- R2: With `accEn`=1 and `clr`=0, `accOut` after the edge equals its previous value plus signed(`opA`)×signed(`opB`), where both operands are 16-bit two's complement.
- R3: With `accEn`=0 and `clr`=0, `accOut` keeps its value regardless of `opA` and `opB`.
- R4: With `clr`=1 and `accEn`=0, `accOut` becomes 0 after the edge regardless of the operands.
- R5: With `clr`=1 and `accEn`=1, `accOut` becomes signed(`opA`)×signed(`opB`) alone, and the previous accumulator value is discarded.
- R6: A sum that leaves the 32-bit range wraps modulo 2^32 with no saturation and no flag.
- R7: The product is exact for the corner operands 0x8000 (most negative), 0x7FFF (most positive), 0xFFFF (−1) and 0x0000 in either operand position, including 0x8000×0x8000 = 0x40000000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| accEn | input | 1 | Add the product into the accumulator on this edge |
| clr | input | 1 | Discard the accumulator contents on this edge |
| opA | input | 16 | Multiplicand, two's complement |
| opB | input | 16 | Multiplier, two's complement, Booth-recoded |
| accOut | output | 32 | Accumulator register value |

## Verification
The accumulator feeds the top of its own adder array, so a single wrong partial-product bit, a misplaced correction bit or a misrouted carry corrupts `accOut` on the very next edge. Because the value is carried forward, the error persists in every later comparison until a clear or reset. A fault in how the control strobes decode the enable and clear inputs shows up as a held value that should have changed, or as a stale sum where a fresh product was expected. Both are visible one cycle after the offending input pair. Corner operands are mixed into the random traffic so that the sign-extension paths of the most negative multiplicand and the negated-double digit are exercised.

// File: rtl/mac_pkg.sv
`timescale 1ns/1ps
package mac_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic loadEn;     // register takes a new value this edge
    logic dropFeed;   // feed zero instead of accumulator into the array
    logic forceZero;  // load zero instead of the array result
  } macStrobe_t;

  localparam int DEF_OP_W  = 16;
  localparam int DEF_ACC_W = 32;
endpackage

// File: rtl/mac_ctrl.sv
`timescale 1ns/1ps
module mac_ctrl
  import mac_pkg::*;
(
  input  logic       accEn,
  input  logic       clr,
  output macStrobe_t strobe
);
  always_comb begin
    strobe.loadEn    = accEn | clr;
    strobe.dropFeed  = clr;
    strobe.forceZero = clr & ~accEn;
  end
endmodule

// File: rtl/mac_booth_recoder.sv
`timescale 1ns/1ps
module mac_booth_recoder #(
  parameter int OP_W  = 16,
  parameter int ACC_W = 32,
  localparam int NPP  = OP_W / 2
) (
  input  logic [OP_W-1:0]             mcand,
  input  logic [OP_W-1:0]             mplier,
  output logic [NPP-1:0][ACC_W-1:0]   ppVec,
  output logic [ACC_W-1:0]            corrVec
);
  logic [OP_W:0]      mplierPad;
  logic [ACC_W-1:0]   mcandExt;
  logic [NPP-1:0]     digNeg;

  assign mplierPad = {mplier, 1'b0};
  assign mcandExt  = {{(ACC_W-OP_W){mcand[OP_W-1]}}, mcand};

  for (genvar i = 0; i < NPP; i++) begin : g_digit
    logic [2:0]       win;
    logic             selOne;
    logic             selTwo;
    logic [ACC_W-1:0] mag;
    logic [ACC_W-1:0] signedMag;

    assign win    = mplierPad[2*i+2 -: 3];
    assign selOne = win[1] ^ win[0];
    assign selTwo = (win[2] & ~win[1] & ~win[0]) | (~win[2] & win[1] & win[0]);
    assign digNeg[i] = win[2];

    always_comb begin
      if (selOne)      mag = mcandExt;
      else if (selTwo) mag = mcandExt << 1;
      else             mag = '0;
      signedMag = win[2] ? ~mag : mag;
    end

    assign ppVec[i] = signedMag << (2*i);
  end

  always_comb begin
    corrVec = '0;
    for (int k = 0; k < NPP; k++) corrVec[2*k] = digNeg[k];
  end
endmodule

// File: rtl/mac_csa_row.sv
`timescale 1ns/1ps
module mac_csa_row #(
  parameter int ACC_W = 32
) (
  input  logic [ACC_W-1:0] inSum,
  input  logic [ACC_W-1:0] inCarry,
  input  logic [ACC_W-1:0] inPp,
  output logic [ACC_W-1:0] outSum,
  output logic [ACC_W-1:0] outCarry
);
  logic [ACC_W-1:0] maj;
  for (genvar b = 0; b < ACC_W; b++) begin : g_fa
    assign outSum[b] = inSum[b] ^ inCarry[b] ^ inPp[b];
    assign maj[b]    = (inSum[b] & inCarry[b]) | (inSum[b] & inPp[b]) | (inCarry[b] & inPp[b]);
  end
  // carry already aligned to the next weight
  assign outCarry = {maj[ACC_W-2:0], 1'b0};
endmodule

// File: rtl/mac_csa_array.sv
`timescale 1ns/1ps
module mac_csa_array #(
  parameter int OP_W  = 16,
  parameter int ACC_W = 32,
  localparam int NPP  = OP_W / 2
) (
  input  logic [ACC_W-1:0]           feedVal,
  input  logic [ACC_W-1:0]           corrVec,
  input  logic [NPP-1:0][ACC_W-1:0]  ppVec,
  output logic [ACC_W-1:0]           total
);
  logic [ACC_W-1:0] rowSum   [NPP+1];
  logic [ACC_W-1:0] rowCarry [NPP+1];

  // accumulator and correction bits enter the top row
  assign rowSum[0]   = feedVal;
  assign rowCarry[0] = corrVec;

  for (genvar r = 0; r < NPP; r++) begin : g_row
    mac_csa_row #(.ACC_W(ACC_W)) u_row (
      .inSum   (rowSum[r]),
      .inCarry (rowCarry[r]),
      .inPp    (ppVec[r]),
      .outSum  (rowSum[r+1]),
      .outCarry(rowCarry[r+1])
    );
  end

  assign total = rowSum[NPP] + rowCarry[NPP];
endmodule

// File: rtl/mac_datapath.sv
`timescale 1ns/1ps
module mac_datapath
  import mac_pkg::*;
#(
  parameter int OP_W  = 16,
  parameter int ACC_W = 32,
  localparam int NPP  = OP_W / 2
) (
  input  logic             clk,
  input  logic             rst,
  input  macStrobe_t       strobe,
  input  logic [OP_W-1:0]  opA,
  input  logic [OP_W-1:0]  opB,
  output logic [ACC_W-1:0] accQ
);
  logic [NPP-1:0][ACC_W-1:0] ppVec;
  logic [ACC_W-1:0]          corrVec;
  logic [ACC_W-1:0]          feedVal;
  logic [ACC_W-1:0]          arrTotal;

  mac_booth_recoder #(.OP_W(OP_W), .ACC_W(ACC_W)) u_booth (
    .mcand  (opA),
    .mplier (opB),
    .ppVec  (ppVec),
    .corrVec(corrVec)
  );

  assign feedVal = strobe.dropFeed ? '0 : accQ;

  mac_csa_array #(.OP_W(OP_W), .ACC_W(ACC_W)) u_array (
    .feedVal(feedVal),
    .corrVec(corrVec),
    .ppVec  (ppVec),
    .total  (arrTotal)
  );

  always_ff @(posedge clk) begin
    if (rst)                   accQ <= '0;
    else if (strobe.loadEn)    accQ <= strobe.forceZero ? '0 : arrTotal;
  end

  // R1: reset empties the register (checked without disable on reset)
  p_reset_zero_r1: assert property (@(posedge clk) rst |=> accQ == '0);
endmodule

// File: rtl/booth_mac.sv
`timescale 1ns/1ps
module booth_mac
  import mac_pkg::*;
#(
  parameter int OP_W  = DEF_OP_W,
  parameter int ACC_W = DEF_ACC_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accEn,
  input  logic             clr,
  input  logic [OP_W-1:0]  opA,
  input  logic [OP_W-1:0]  opB,
  output logic [ACC_W-1:0] accOut
);
  macStrobe_t strobe;

  mac_ctrl u_ctrl (
    .accEn (accEn),
    .clr   (clr),
    .strobe(strobe)
  );

  mac_datapath #(.OP_W(OP_W), .ACC_W(ACC_W)) u_dp (
    .clk   (clk),
    .rst   (rst),
    .strobe(strobe),
    .opA   (opA),
    .opB   (opB),
    .accQ  (accOut)
  );

  // Reference product built by plain signed multiply, not by the Booth array
  logic [ACC_W-1:0] refProd;
  assign refProd = $signed({{(ACC_W-OP_W){opA[OP_W-1]}}, opA})
                 * $signed({{(ACC_W-OP_W){opB[OP_W-1]}}, opB});

  // R2 and R6: accumulate with modulo-2^ACC_W wrap
  p_accumulate_r2: assert property (@(posedge clk) disable iff (rst)
    (accEn && !clr) |=> accOut == $past(accOut + refProd));

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!accEn && !clr) |=> $stable(accOut));

  p_clear_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (clr && !accEn) |=> accOut == '0);

  p_load_product_r5: assert property (@(posedge clk) disable iff (rst)
    (clr && accEn) |=> accOut == $past(refProd));
endmodule

// File: tb/sim_booth_mac.sv
`timescale 1ns/1ps
module sim_booth_mac;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        accEn = 1'b0;
  logic        clr = 1'b0;
  logic [15:0] opA = '0;
  logic [15:0] opB = '0;
  logic [31:0] accOut;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 1'b0;
  logic [31:0] expAcc = '0;

  always #2 clk = ~clk;  // 250 MHz

  booth_mac u0 (
    .clk(clk), .rst(rst), .accEn(accEn), .clr(clr),
    .opA(opA), .opB(opB), .accOut(accOut)
  );

  function automatic logic [31:0] mulRef(input logic [15:0] a, input logic [15:0] b);
    logic signed [31:0] ea, eb;
    ea = $signed({{16{a[15]}}, a});
    eb = $signed({{16{b[15]}}, b});
    return 32'(ea * eb);
  endfunction

  function automatic logic [31:0] nextRef(input logic [31:0] acc, input logic en,
                                          input logic cl, input logic [15:0] a,
                                          input logic [15:0] b);
    if (cl && en) return mulRef(a, b);
    if (cl)       return 32'd0;
    if (en)       return acc + mulRef(a, b);
    return acc;
  endfunction

  function automatic logic [15:0] corner(input int k);
    case (k % 4)
      0: return 16'h8000;
      1: return 16'h7FFF;
      2: return 16'hFFFF;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic check(input string tag);
    nChecks++;
    if (accOut !== expAcc) begin
      nFails++;
      $display("FAIL %s: accOut actual=%08h expected=%08h", tag, accOut, expAcc);
    end
  endtask

  task automatic step(input logic en, input logic cl, input logic [15:0] a,
                      input logic [15:0] b, input string tag);
    @(negedge clk);
    accEn = en; clr = cl; opA = a; opB = b;
    expAcc = nextRef(expAcc, en, cl, a, b);
    @(posedge clk);
    #1;
    check(tag);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; accEn = 1'b1; opA = 16'h1234; opB = 16'h5678;
    @(posedge clk);
    #1;
    expAcc = '0;
    check("R1 reset");
    @(negedge clk);
    rst = 1'b0; accEn = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (2) @(posedge clk);
    doReset();

    // R7 corner products, each seeded by clear+enable (R5) then accumulated (R2)
    step(1, 1, 16'h8000, 16'h8000, "R7 min*min");
    step(1, 1, 16'h7FFF, 16'h8000, "R7 max*min");
    step(1, 1, 16'hFFFF, 16'hFFFF, "R7 neg1*neg1");
    step(1, 1, 16'h0000, 16'h7FFF, "R7 zero*max");
    step(1, 1, 16'h8000, 16'hFFFF, "R7 min*neg1");
    step(1, 1, 16'h7FFF, 16'h7FFF, "R7 max*max");
    for (int i = 0; i < 16; i++)
      step(1, 0, corner(i), corner(i / 4), "R7 corner accumulate");

    // R2 plain accumulation
    step(1, 1, 16'd3, 16'd5, "R5 seed");
    step(1, 0, 16'hFFFE, 16'd7, "R2 neg add");
    step(1, 0, 16'd100, 16'hFF9C, "R2 neg mult");

    // R3 hold with changing operands
    step(0, 0, 16'h7FFF, 16'h7FFF, "R3 hold");
    step(0, 0, 16'h8000, 16'h1234, "R3 hold");

    // R4 clear alone
    step(0, 1, 16'h7FFF, 16'h7FFF, "R4 clear");
    step(0, 0, 16'h0000, 16'h0000, "R4 stays zero");

    // R6 wrap beyond 32 bits
    for (int i = 0; i < 6; i++) step(1, 0, 16'h8000, 16'h8000, "R6 wrap");
    for (int i = 0; i < 6; i++) step(1, 0, 16'h8000, 16'h7FFF, "R6 wrap neg");

    // random traffic with mixed corners
    for (int i = 0; i < 3000; i++) begin
      logic en, cl;
      logic [15:0] a, b;
      string tag;
      en = ($urandom % 4) != 0;
      cl = ($urandom % 20) == 0;
      a  = ($urandom % 8 == 0) ? corner(int'($urandom % 4)) : 16'($urandom);
      b  = ($urandom % 8 == 0) ? corner(int'($urandom % 4)) : 16'($urandom);
      if (cl && en)  tag = "R5 random";
      else if (cl)   tag = "R4 random";
      else if (en)   tag = "R2 random";
      else           tag = "R3 random";
      step(en, cl, a, b, tag);
      if (i == 1500) doReset();
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule